// File: doc/BRIEF.md
# Parallel ROM Read Access Controller

This block lets a synchronous host read 16-bit words from an asynchronous parallel ROM that has a separate active-low chip enable and an active-low output enable. The host offers an 18-bit word address with a valid/ready handshake. The controller then drives the address and pulls chip enable low. It lowers output enable late enough that all three access paths end on the same clock edge: address-to-data, chip-enable-to-data and output-enable-to-data. On that edge it samples the ROM data pins and returns the word with a one-cycle strobe.

After the sample, output enable goes high. The controller then waits out the output float time before it starts another access, so the ROM can never still be driving the shared pins when the next access begins. Every timing limit is a cycle-count parameter, so a different speed grade or clock rate needs only new parameter values. With the defaults at a 100 MHz clock, the counts are 9 cycles for address access (90 ns), 9 for chip-enable access (90 ns), 5 for output-enable access (50 ns) and 3 for output float (30 ns).

The `IDLE_STANDBY` parameter selects what chip enable does between reads. When it is set, chip enable goes high after each access and the ROM drops into low-power standby. When it is clear, chip enable stays low for back-to-back reads.

The behaviour is held in three states:
- `ST_IDLE` waits for a request.
- `ST_WAIT_DATA` counts the access time.
- `ST_RECOVER` counts the float time.

The transitions are:
- start (`ST_IDLE` to `ST_WAIT_DATA` on a handshake).
- capture (`ST_WAIT_DATA` to `ST_RECOVER` on the sample edge).
- restart (`ST_RECOVER` to `ST_WAIT_DATA` when a held request is taken on the last float cycle).
- settle (`ST_RECOVER` to `ST_IDLE` when the float time has ended with no request).

Top module: `prom_read_ctrl`

## Requirements
- R1: After reset, `rom_ce_n` and `rom_oe_n` are 1, `rsp_valid` is 0 and `req_ready` is 1.
- R2: On a clock edge where `req_valid` and `req_ready` are both 1, `rom_addr` takes all 18 bits of `req_addr` and `rom_ce_n` goes to 0. `rom_addr` then holds its value until the next handshake.
- R3: `rom_oe_n` goes to 0 exactly `W - T_OE_CYC` cycles after the handshake edge, where `W = max(T_ACC_CYC, T_CE_CYC, T_OE_CYC)` (4 cycles with the defaults).
- R4: The ROM data pins are sampled on the edge `W` cycles after the handshake. `rsp_valid` is then 1 for exactly one cycle and carries the sampled word on `rsp_data`. Each accepted request gives exactly one response.
- R5: `rom_oe_n` returns to 1 on the sample edge, so it is already 1 while `rsp_valid` is 1. `rom_oe_n` is never 0 while `rom_ce_n` is 1.
- R6: `req_ready` stays 0 from the handshake until `T_DF_CYC` cycles after `rom_oe_n` rises. Two accepted requests are therefore at least `W + T_DF_CYC` cycles apart (12 with the defaults).
- R7: A request that is held valid while `req_ready` is 0 is neither dropped nor altered. It starts on the first edge the float time allows, exactly `W + T_DF_CYC` cycles after the previous start.
- R8: With `IDLE_STANDBY` = 1, `rom_ce_n` returns to 1 on the sample edge and stays 1 until the next handshake.
- R9: With `IDLE_STANDBY` = 0, `rom_ce_n` stays 0 after the first access. Responses keep the same cycle timing and data as with standby on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Read request offered |
| req_addr | input | ADDR_W | Word address of the request |
| req_ready | output | 1 | Controller can start a request this cycle |
| rsp_valid | output | 1 | One-cycle strobe: `rsp_data` holds the read word |
| rsp_data | output | DATA_W | Word read from the ROM |
| rom_addr | output | ADDR_W | Address pins to the ROM |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_data | input | DATA_W | Data pins from the ROM |

## Verification
A wrong count in the access counter moves the sample edge away from cycle `W`. This shows up on the very first read, either as a poisoned word or as a response that is late. A state machine stuck in the access state or the recovery state freezes `req_ready` at 0, which stops the next request. A recovery that ends early shows as a shorter gap between two held requests. A wrong standby choice shows on `rom_ce_n` at the first response strobe.

// File: rtl/prom_rd_pkg.sv
package prom_rd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WAIT_DATA = 2'd1,
        ST_RECOVER   = 2'd2
    } prom_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prom_rd_timer.sv
// Saturating cycle counter; clear restarts it at zero.
module prom_rd_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '1;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != '1) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/prom_rd_capture.sv
// Registers the ROM word on the sample edge and raises a one-cycle strobe.
module prom_rd_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cap_en;
            if (cap_en) begin
                rsp_data <= din;
            end
        end
    end

endmodule

// File: rtl/prom_read_ctrl.sv
module prom_read_ctrl
    import prom_rd_pkg::*;
#(
    parameter int ADDR_W       = 18,
    parameter int DATA_W       = 16,
    parameter int T_ACC_CYC    = 9,
    parameter int T_CE_CYC     = 9,
    parameter int T_OE_CYC     = 5,
    parameter int T_DF_CYC     = 3,
    parameter bit IDLE_STANDBY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    input  logic [DATA_W-1:0] rom_data
);

    // Longest access path decides the sample edge; OE is delayed by the slack.
    localparam int W_CYC   = imax(imax(T_ACC_CYC, T_CE_CYC), T_OE_CYC);
    localparam int OE_LEAD = W_CYC - T_OE_CYC;
    localparam int CNT_W   = $clog2(imax(W_CYC, T_DF_CYC) + 1);

    localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(W_CYC - 1);
    localparam logic [CNT_W-1:0] OE_PRE    = CNT_W'(OE_LEAD - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(T_DF_CYC - 1);

    prom_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt;
    logic              start;
    logic              wait_last;
    logic              rec_done;
    logic              oe_due;
    logic [ADDR_W-1:0] addr_q;
    logic              ce_q;
    logic              oe_q;

    assign wait_last = (state_q == ST_WAIT_DATA) && (cnt == LAST_WAIT);
    assign rec_done  = (state_q == ST_RECOVER) && (cnt == REC_LAST);
    assign req_ready = (state_q == ST_IDLE) || rec_done;
    assign start     = req_valid && req_ready;
    assign oe_due    = (OE_LEAD > 0) && (cnt == OE_PRE);

    prom_rd_timer #(.CNT_W(CNT_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start || wait_last),
        .cnt   (cnt)
    );

    prom_rd_capture #(.DATA_W(DATA_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_en    (wait_last),
        .din       (rom_data),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_WAIT_DATA;        // start
            end
            ST_WAIT_DATA: begin
                if (wait_last) state_d = ST_RECOVER;      // capture
            end
            ST_RECOVER: begin
                if (start)         state_d = ST_WAIT_DATA; // restart
                else if (rec_done) state_d = ST_IDLE;      // settle
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ROM pin outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            ce_q   <= 1'b1;
            oe_q   <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_RECOVER: begin
                    if (start) begin
                        addr_q <= req_addr;
                        ce_q   <= 1'b0;
                        oe_q   <= (OE_LEAD != 0);
                    end else if (IDLE_STANDBY) begin
                        ce_q   <= 1'b1;
                    end
                end
                ST_WAIT_DATA: begin
                    if (wait_last) begin
                        oe_q <= 1'b1;
                        ce_q <= IDLE_STANDBY;
                    end else if (oe_due) begin
                        oe_q <= 1'b0;
                    end
                end
                default: begin
                    oe_q <= 1'b1;
                end
            endcase
        end
    end

    assign rom_addr = addr_q;
    assign rom_ce_n = ce_q;
    assign rom_oe_n = oe_q;

endmodule

// File: rtl/prom_read_ctrl_chk.sv
module prom_read_ctrl_chk #(
    parameter int ADDR_W   = 18,
    parameter int T_DF_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_ce_n,
    input logic              rom_oe_n
);

    // Cycles since output enable was last low, capped at the float count.
    int since_oe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             since_oe <= T_DF_CYC;
        else if (!rom_oe_n)     since_oe <= 0;
        else if (since_oe < T_DF_CYC) since_oe <= since_oe + 1;
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |=> $stable(rom_addr));

    // R4
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R5
    ce_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !rom_ce_n);

    // R5
    rsp_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $rose(rom_oe_n));

    // R6
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_oe_n |-> !req_ready);

    // R6
    float_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> (since_oe + 1 >= T_DF_CYC));

endmodule

bind prom_read_ctrl prom_read_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .T_DF_CYC (T_DF_CYC)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rom_addr  (rom_addr),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n)
);

// File: tb/test_prom_read_ctrl.sv
// ROM model: drives the true word only once every access path has had its time;
// before that it drives the inverted word so early sampling is visible.
module prom_model_tb #(
    parameter int T_ACC = 9,
    parameter int T_CE  = 9,
    parameter int T_OE  = 5
) (
    input  logic        clk,
    input  logic [17:0] addr,
    input  logic        ce_n,
    input  logic        oe_n,
    output logic [15:0] data
);
    function automatic logic [15:0] word_of(input logic [17:0] a);
        return a[15:0] ^ {a[17:16], a[17:16], 12'h5A3};
    endfunction

    int          a_age  = 1000;
    int          c_age  = 1000;
    int          o_age  = 1000;
    logic [17:0] last_a = '0;
    logic        prev_c = 1'b1;
    logic        prev_o = 1'b1;

    initial data = 16'h0;

    always @(negedge clk) begin
        if (addr != last_a) a_age = 0;
        else if (a_age < 1000) a_age++;
        if (ce_n || prev_c) c_age = 0;
        else if (c_age < 1000) c_age++;
        if (oe_n || prev_o) o_age = 0;
        else if (o_age < 1000) o_age++;
        last_a = addr;
        prev_c = ce_n;
        prev_o = oe_n;
        if (!ce_n && !oe_n && a_age + 1 >= T_ACC && c_age + 1 >= T_CE && o_age + 1 >= T_OE)
            data = word_of(addr);
        else
            data = ~word_of(addr);
    end
endmodule

module test_prom_read_ctrl;
    localparam int T_ACC = 9;
    localparam int T_CE  = 9;
    localparam int T_OE  = 5;
    localparam int T_DF  = 3;
    localparam int W     = 9;
    localparam int LEAD  = W - T_OE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [17:0] req_addr = '0;

    logic        req_ready, rsp_valid, rom_ce_n, rom_oe_n;
    logic [15:0] rsp_data, rom_data;
    logic [17:0] rom_addr;
    logic        h_ready, h_rsp_valid, h_ce_n, h_oe_n;
    logic [15:0] h_rsp_data, h_rom_data;
    logic [17:0] h_rom_addr;

    always #5 clk = ~clk;

    prom_read_ctrl #(.T_ACC_CYC(T_ACC), .T_CE_CYC(T_CE), .T_OE_CYC(T_OE),
                     .T_DF_CYC(T_DF), .IDLE_STANDBY(1'b1)) i_prom_read_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rom_addr(rom_addr), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n),
        .rom_data(rom_data));

    prom_model_tb #(.T_ACC(T_ACC), .T_CE(T_CE), .T_OE(T_OE)) i_rom (
        .clk(clk), .addr(rom_addr), .ce_n(rom_ce_n), .oe_n(rom_oe_n), .data(rom_data));

    prom_read_ctrl #(.T_ACC_CYC(T_ACC), .T_CE_CYC(T_CE), .T_OE_CYC(T_OE),
                     .T_DF_CYC(T_DF), .IDLE_STANDBY(1'b0)) i_prom_read_ctrl_hold (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(h_ready), .rsp_valid(h_rsp_valid), .rsp_data(h_rsp_data),
        .rom_addr(h_rom_addr), .rom_ce_n(h_ce_n), .rom_oe_n(h_oe_n),
        .rom_data(h_rom_data));

    prom_model_tb #(.T_ACC(T_ACC), .T_CE(T_CE), .T_OE(T_OE)) i_rom_hold (
        .clk(clk), .addr(h_rom_addr), .ce_n(h_ce_n), .oe_n(h_oe_n), .data(h_rom_data));

    function automatic logic [15:0] word_of(input logic [17:0] a);
        return a[15:0] ^ {a[17:16], a[17:16], 12'h5A3};
    endfunction

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    int          last_acc = 0;
    logic        prev_oe = 1'b1;
    logic [15:0] exp_q[$];
    int          acc_q[$];
    logic [17:0] adr_q[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: offers a request, holds it until taken, records expectations.
    task automatic issue(input logic [17:0] a, input bit gap_chk);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        while (!req_ready) @(negedge clk);
        // R6 R7: held request starts exactly W + T_DF after the previous one
        if (gap_chk) check(cyc - last_acc == W + T_DF, "R7 start gap", cyc - last_acc, W + T_DF);
        last_acc = cyc;
        exp_q.push_back(word_of(a));
        acc_q.push_back(cyc);
        adr_q.push_back(a);
        @(posedge clk);
    endtask

    task automatic release_req();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_oe && !rom_oe_n) begin
                check(cyc - last_acc - 1 == LEAD, "R3 oe lead", cyc - last_acc - 1, LEAD);
                check(rom_ce_n == 1'b0, "R2 ce low at access", rom_ce_n, 0);
            end
            prev_oe = rom_oe_n;
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected response", rsp_data, 0);
                end else begin
                    logic [15:0] e;
                    int          a0;
                    logic [17:0] ad;
                    e  = exp_q.pop_front();
                    a0 = acc_q.pop_front();
                    ad = adr_q.pop_front();
                    check(rsp_data == e, "R4 data", rsp_data, e);
                    check(cyc - a0 - 1 == W, "R4 latency", cyc - a0 - 1, W);
                    check(rom_addr == ad, "R2 address", rom_addr, ad);
                    check(rom_oe_n == 1'b1, "R5 oe high at strobe", rom_oe_n, 1);
                    check(req_ready == 1'b0, "R6 ready low in float", req_ready, 0);
                    check(rom_ce_n == 1'b1, "R8 standby ce", rom_ce_n, 1);
                    check(h_rsp_valid && h_rsp_data == e, "R9 hold data", h_rsp_data, e);
                    check(h_ce_n == 1'b0, "R9 hold ce low", h_ce_n, 0);
                end
            end else if (h_rsp_valid) begin
                check(1'b0, "R9 hold extra strobe", 1, 0);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rom_ce_n == 1'b1, "R1 ce", rom_ce_n, 1);
        check(rom_oe_n == 1'b1, "R1 oe", rom_oe_n, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        rst_n = 1'b1;

        issue(18'h00000, 1'b0);
        release_req();
        repeat (20) @(negedge clk);
        // R8: idle between reads keeps chip enable high
        check(rom_ce_n == 1'b1, "R8 idle ce", rom_ce_n, 1);
        check(h_ce_n == 1'b0, "R9 idle hold ce", h_ce_n, 0);
        issue(18'h3FFFF, 1'b0);
        release_req();
        repeat (20) @(negedge clk);
        // back-to-back burst with the request held through float (R7)
        issue(18'h2AAAA, 1'b0);
        issue(18'h15555, 1'b1);
        issue(18'h00F0F, 1'b1);
        issue(18'h3C3C3, 1'b1);
        release_req();
        repeat (30) @(negedge clk);
        issue(18'h3C3C3, 1'b0);
        release_req();
        repeat (30) @(negedge clk);

        check(exp_q.size() == 0, "R4 all responses seen", exp_q.size(), 0);
        check(rom_ce_n == 1'b1 && req_ready == 1'b1, "R8 final idle", rom_ce_n, 1);
        check(h_ce_n == 1'b0, "R9 final hold ce", h_ce_n, 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule